// File: doc/BRIEF.md
# Dual-Width Static Memory Control and Lane Steering

This block is a clocked model of the control side of a 16-bit static memory that can also run as an 8-bit memory. It decodes two chip enables of opposite polarity, a write strobe, an output strobe, two lane selects and a width-mode input. From that decode it writes the chosen byte lanes of a small internal array, or drives the chosen lanes of the data bus. The bidirectional bus is split into an input vector, an output vector and a per-bit drive-enable vector. A drive enable of 0 stands for a floating pin.

The array is built as two equal 8-bit halves. One half holds the low byte of every word and the other holds the high byte. In 16-bit mode the lane selects choose the halves. In 8-bit mode the lane selects are ignored. Bit 15 of the data input then acts as the least significant address bit and picks the half, and only bits 7..0 carry data. The control inputs are sampled on every rising clock edge. A write commits at that edge. Read data and drive enables appear on registered outputs after the same edge.

Top module: `bw_sram_ctl`

## Requirements
- R1: While reset is active, and after reset until the first operation, `d_drv` and `d_out` are all zero.
- R2: The part is idle, with `d_drv` zero and no array change, when `en_a_n` is 1, or `en_b` is 0, or (with `wide_mode` = 1) both `hi_lane_n` and `lo_lane_n` are 1.
- R3: A write happens at a clock edge only when all of these hold at that edge: `en_a_n` = 0, `en_b` = 1, `wr_en_n` = 0, and (in 16-bit mode) at least one lane select is 0. In 16-bit mode `d_in[7:0]` goes to the low half when `lo_lane_n` = 0, and `d_in[15:8]` goes to the high half when `hi_lane_n` = 0. A half that is not selected keeps its contents.
- R4: A 16-bit read (`wr_en_n` = 1, `out_en_n` = 0) drives `d_out[7:0]` with the low half when `lo_lane_n` = 0, and `d_out[15:8]` with the high half when `hi_lane_n` = 0. The lanes that are not selected have `d_drv` = 0 and `d_out` = 0. The result is visible after the sampling edge.
- R5: With `out_en_n` = 1, `d_drv` is zero even when the part is selected.
- R6: With `wr_en_n` = 0, `d_drv` is zero whatever the value of `out_en_n`.
- R7: In 8-bit mode (`wide_mode` = 0), `d_in[15]` = 0 selects the low half and `d_in[15]` = 1 selects the high half at word `addr`. Data is read and written on bits 7..0 only. `d_drv` is `16'h00FF` on a read and `d_drv[15:8]` is always zero.
- R8: In 8-bit mode the lane selects have no effect, including when both are 1.
- R9: Both widths use the same storage. A byte written in 8-bit mode is read back in the matching lane in 16-bit mode.
- R10: A write at one edge is returned by a read sampled at the very next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en_a_n | input | 1 | Chip enable, active low |
| en_b | input | 1 | Chip enable, active high |
| wr_en_n | input | 1 | Write strobe, active low |
| out_en_n | input | 1 | Output strobe, active low |
| hi_lane_n | input | 1 | High-lane select, active low (16-bit mode only) |
| lo_lane_n | input | 1 | Low-lane select, active low (16-bit mode only) |
| wide_mode | input | 1 | 1 = 16-bit mode, 0 = 8-bit mode |
| addr | input | IDX_W | Word address |
| d_in | input | 16 | Bus input side; bit 15 is the extra address bit in 8-bit mode |
| d_out | output | 16 | Bus output side (registered) |
| d_drv | output | 16 | Per-bit drive enable (registered); 0 means floating |

## Verification
The hardest case to reach from the ports is the 8-bit path. There, one data pin changes role and becomes an address bit, while the lane selects must be shown to have no effect. The stimulus first fills every word with a distinct pattern in 16-bit mode. It then runs 8-bit reads and writes with the lane selects in every combination, including both deasserted, and flips bit 15 to steer between the halves. Finally it reads the same words back in 16-bit mode to show that each byte landed in the correct half. The bench also commits a write at one edge and reads the same word at the next edge, and it issues writes under each idle condition and reads afterwards to prove that nothing changed.

// File: rtl/bw_sram_pkg.sv
package bw_sram_pkg;

  typedef struct packed {
    logic wr;       // commit a write this edge
    logic rd;       // drive read data after this edge
    logic lane_lo;  // low half is the target
    logic lane_hi;  // high half is the target
    logic narrow;   // 8-bit mode active
    logic bsel;     // extra low address bit in 8-bit mode
  } dec_t;

endpackage

// File: rtl/bw_sram_decode.sv
module bw_sram_decode
  import bw_sram_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic                en_a_n,
  input  logic                en_b,
  input  logic                wr_en_n,
  input  logic                out_en_n,
  input  logic                hi_lane_n,
  input  logic                lo_lane_n,
  input  logic                wide_mode,
  input  logic                xbit,
  output dec_t                dec
);

  logic chip_on;
  logic lane_any;

  always_comb begin
    chip_on     = !en_a_n && en_b;
    lane_any    = !(hi_lane_n && lo_lane_n);
    dec.narrow  = !wide_mode;
    dec.bsel    = dec.narrow && xbit;
    if (dec.narrow) begin
      dec.lane_lo = !xbit;
      dec.lane_hi = xbit;
    end else begin
      dec.lane_lo = !lo_lane_n;
      dec.lane_hi = !hi_lane_n;
    end
    dec.wr = chip_on && (dec.narrow || lane_any) && !wr_en_n;
    dec.rd = chip_on && (dec.narrow || lane_any) && wr_en_n && !out_en_n;
  end

  // narrow mode always targets exactly one half
  always_comb begin
    if (dec.narrow) begin
      narrow_one_lane_chk: assert (dec.lane_lo != dec.lane_hi);
    end
  end

endmodule

// File: rtl/bw_sram_bank.sv
module bw_sram_bank #(
  parameter int WORDS  = 256,
  parameter int LANE_W = 8,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [LANE_W-1:0] wdata,
  output logic [LANE_W-1:0] rdata
);

  logic [LANE_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[idx] <= wdata;
    end
  end

  assign rdata = mem[idx];

endmodule

// File: rtl/bw_sram_outstage.sv
module bw_sram_outstage
  import bw_sram_pkg::*;
#(
  parameter int LANE_W = 8,
  localparam int BUS_W = 2 * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dec_t              dec,
  input  logic [LANE_W-1:0] lo_data,
  input  logic [LANE_W-1:0] hi_data,
  output logic [BUS_W-1:0]  d_out,
  output logic [BUS_W-1:0]  d_drv
);

  logic [BUS_W-1:0] out_d;
  logic [BUS_W-1:0] drv_d;

  always_comb begin
    out_d = '0;
    drv_d = '0;
    if (dec.rd) begin
      if (dec.narrow) begin
        out_d[LANE_W-1:0] = dec.bsel ? hi_data : lo_data;
        drv_d[LANE_W-1:0] = '1;
      end else begin
        if (dec.lane_lo) begin
          out_d[LANE_W-1:0] = lo_data;
          drv_d[LANE_W-1:0] = '1;
        end
        if (dec.lane_hi) begin
          out_d[BUS_W-1:LANE_W] = hi_data;
          drv_d[BUS_W-1:LANE_W] = '1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_out <= '0;
      d_drv <= '0;
    end else begin
      d_out <= out_d;
      d_drv <= drv_d;
    end
  end

  // R4
  undriven_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((d_out & ~d_drv) == '0));

endmodule

// File: rtl/bw_sram_ctl.sv
module bw_sram_ctl
  import bw_sram_pkg::*;
#(
  parameter int WORDS  = 256,
  parameter int LANE_W = 8,
  localparam int IDX_W = $clog2(WORDS),
  localparam int BUS_W = 2 * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_a_n,
  input  logic             en_b,
  input  logic             wr_en_n,
  input  logic             out_en_n,
  input  logic             hi_lane_n,
  input  logic             lo_lane_n,
  input  logic             wide_mode,
  input  logic [IDX_W-1:0] addr,
  input  logic [BUS_W-1:0] d_in,
  output logic [BUS_W-1:0] d_out,
  output logic [BUS_W-1:0] d_drv
);

  logic             rst_meta;
  logic             rst_q;
  dec_t             dec;
  logic [LANE_W-1:0] lane_rd [2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  bw_sram_decode #(.LANE_W(LANE_W)) u_dec (
    .en_a_n    (en_a_n),
    .en_b      (en_b),
    .wr_en_n   (wr_en_n),
    .out_en_n  (out_en_n),
    .hi_lane_n (hi_lane_n),
    .lo_lane_n (lo_lane_n),
    .wide_mode (wide_mode),
    .xbit      (d_in[BUS_W-1]),
    .dec       (dec)
  );

  for (genvar g = 0; g < 2; g++) begin : g_half
    logic              half_we;
    logic [LANE_W-1:0] half_wd;
    always_comb begin
      half_we = rst_q && dec.wr && ((g == 0) ? dec.lane_lo : dec.lane_hi);
      if (g == 0 || dec.narrow) half_wd = d_in[LANE_W-1:0];
      else                      half_wd = d_in[BUS_W-1:LANE_W];
    end
    bw_sram_bank #(.WORDS(WORDS), .LANE_W(LANE_W)) u_bank (
      .clk   (clk),
      .we    (half_we),
      .idx   (addr),
      .wdata (half_wd),
      .rdata (lane_rd[g])
    );
  end

  bw_sram_outstage #(.LANE_W(LANE_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_q),
    .dec     (dec),
    .lo_data (lane_rd[0]),
    .hi_data (lane_rd[1]),
    .d_out   (d_out),
    .d_drv   (d_drv)
  );

  // R2
  deselect_float_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (en_a_n || !en_b) |=> (d_drv == '0));

  // R5
  oe_off_float_chk: assert property (@(posedge clk) disable iff (!rst_q)
    out_en_n |=> (d_drv == '0));

  // R6
  write_float_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !wr_en_n |=> (d_drv == '0));

  // R7
  narrow_upper_float_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !wide_mode |=> (d_drv[BUS_W-1:LANE_W] == '0));

  // R4
  lo_unsel_float_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (wide_mode && lo_lane_n) |=> (d_drv[LANE_W-1:0] == '0));

  // R4
  hi_unsel_float_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (wide_mode && hi_lane_n) |=> (d_drv[BUS_W-1:LANE_W] == '0));

endmodule

// File: tb/bw_sram_ctl_tb.sv
module bw_sram_ctl_tb;

  localparam int WORDS = 256;
  localparam int IDX_W = $clog2(WORDS);

  typedef struct {
    logic [15:0] out;
    logic [15:0] drv;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic en_a_n, en_b, wr_en_n, out_en_n, hi_lane_n, lo_lane_n, wide_mode;
  logic [IDX_W-1:0] addr;
  logic [15:0] d_in, d_out, d_drv;

  logic [15:0] ref_mem [WORDS];
  exp_t        q [$];
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  bw_sram_ctl #(.WORDS(WORDS)) u_dut (
    .clk(clk), .rst_n(rst_n), .en_a_n(en_a_n), .en_b(en_b),
    .wr_en_n(wr_en_n), .out_en_n(out_en_n), .hi_lane_n(hi_lane_n),
    .lo_lane_n(lo_lane_n), .wide_mode(wide_mode), .addr(addr),
    .d_in(d_in), .d_out(d_out), .d_drv(d_drv)
  );

  // drive one operation; expectation follows the requirements
  task automatic op(input logic a_n, input logic b, input logic wn,
                    input logic on, input logic hn, input logic ln,
                    input logic wide, input int ad, input logic [15:0] din,
                    input string tag);
    logic sel, llo, lhi, bs;
    exp_t e;
    @(negedge clk);
    en_a_n = a_n; en_b = b; wr_en_n = wn; out_en_n = on;
    hi_lane_n = hn; lo_lane_n = ln; wide_mode = wide;
    addr = IDX_W'(ad); d_in = din;
    bs  = din[15];
    sel = !a_n && b && (!wide || !(hn && ln));
    llo = wide ? !ln : !bs;
    lhi = wide ? !hn : bs;
    e.out = '0; e.drv = '0; e.tag = tag;
    if (sel && wn && !on) begin
      if (!wide) begin
        e.out[7:0] = bs ? ref_mem[ad][15:8] : ref_mem[ad][7:0];
        e.drv = 16'h00FF;
      end else begin
        if (llo) begin e.out[7:0]  = ref_mem[ad][7:0];  e.drv[7:0]  = 8'hFF; end
        if (lhi) begin e.out[15:8] = ref_mem[ad][15:8]; e.drv[15:8] = 8'hFF; end
      end
    end
    if (sel && !wn) begin
      if (llo) ref_mem[ad][7:0]  = din[7:0];
      if (lhi) ref_mem[ad][15:8] = wide ? din[15:8] : din[7:0];
    end
    q.push_back(e);
  endtask

  task automatic idle();
    op(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 0, 16'h0, "R2 idle");
  endtask

  // monitor: compare each result just after the edge that produced it
  always @(posedge clk) begin
    exp_t e;
    #1;
    if (q.size() > 0) begin
      e = q.pop_front();
      checks++;
      if (d_out !== e.out || d_drv !== e.drv) begin
        errors++;
        $display("FAIL %s: out=%h drv=%h expected out=%h drv=%h",
                 e.tag, d_out, d_drv, e.out, e.drv);
      end
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0;
    en_a_n = 1'b0; en_b = 1'b1; wr_en_n = 1'b1; out_en_n = 1'b0;
    hi_lane_n = 1'b0; lo_lane_n = 1'b0; wide_mode = 1'b1;
    addr = '0; d_in = '0;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (d_drv !== 16'h0 || d_out !== 16'h0) begin
      errors++;
      $display("FAIL R1 reset: out=%h drv=%h expected out=0000 drv=0000", d_out, d_drv);
    end
    @(negedge clk);
    en_a_n = 1'b1;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    checks++;
    if (d_drv !== 16'h0 || d_out !== 16'h0) begin
      errors++;
      $display("FAIL R1 post-reset: out=%h drv=%h expected out=0000 drv=0000", d_out, d_drv);
    end

    // R3 fill every word; odd words with output strobe low (R6)
    for (int i = 0; i < WORDS; i++) begin
      ref_mem[i] = '0;
      op(1'b0, 1'b1, 1'b0, i[0] ? 1'b0 : 1'b1, 1'b0, 1'b0, 1'b1, i,
         {i[7:0] ^ 8'hA5, i[7:0]}, "R3/R6 word write");
    end

    // R4 full, low-only, high-only reads
    op(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 5,   16'h0, "R4 word read");
    op(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 17,  16'h0, "R4 low read");
    op(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 200, 16'h0, "R4 high read");

    // R5 output strobe high while selected
    op(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 5, 16'h0, "R5 oe high");

    // R2 each idle condition, with write attempts that must not land
    op(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 9, 16'hDEAD, "R2 en_a high");
    op(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 9, 16'hBEEF, "R2 en_b low");
    op(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 9, 16'hCAFE, "R2 R3 no lane");
    op(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 9, 16'h0,    "R2 no lane read");
    op(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 9, 16'h0,    "R2 word 9 unchanged");

    // R3 low-lane-only and high-lane-only writes, R10 back-to-back read
    op(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 30, 16'h1234, "R3 low write");
    op(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 30, 16'h0,    "R3 R10 low write readback");
    op(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 31, 16'h5678, "R3 R6 high write");
    op(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 31, 16'h0,    "R3 R10 high write readback");

    // R7 8-bit reads of both halves, R8 with lane selects in every state
    op(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 40, 16'h0000, "R7 narrow low half");
    op(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 40, 16'h8000, "R7 narrow high half");
    op(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 41, 16'h8000, "R8 narrow both lanes off");
    op(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 41, 16'h8000, "R8 narrow low lane only");
    op(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 41, 16'h0000, "R8 narrow high lane only");

    // R7 R8 8-bit writes (upper data bits set to prove they are ignored)
    op(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 50, 16'hFF3C, "R7 R8 narrow write high");
    op(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 51, 16'h7FC3, "R7 narrow write low");
    op(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 50, 16'h8000, "R7 R10 narrow readback");

    // R9 16-bit view of 8-bit writes
    op(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 50, 16'h0, "R9 word view of 50");
    op(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 51, 16'h0, "R9 word view of 51");

    // R2 deselect in 8-bit mode
    op(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 50, 16'h8000, "R2 narrow deselect");

    // sweep reads over the array in both widths
    for (int i = 0; i < WORDS; i += 37) begin
      op(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, i, 16'h0, "R4 sweep word read");
      op(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, i, {i[0], 15'h0}, "R7 sweep narrow read");
    end

    idle();
    repeat (3) @(posedge clk);
    #2;
    summary();
  end

endmodule